// File: doc/BRIEF.md
# Shared-Bus SRAM and Flash Access Controller

This block sits between a synchronous host request port and a memory module where a 32-bit SRAM and a 32-bit flash share one address bus, one data bus and one output enable. Each side has its own chip select and its own write enable for every byte lane. A host request gives a word address, a read or write flag, four byte enables, a target select (SRAM or flash) and write data. The controller runs the strobe sequence for the chosen device and returns one response pulse. A read response carries the captured data.

Every request goes through the same phases: setup, active and recovery. Chip select is low during setup and active. During the active phase the output enable falls for a read, or the chosen byte-lane write enables fall for a write. During recovery every strobe is high, so the device bus can float or the write can recover. Each phase length in clock cycles is worked out at elaboration by ceiling-dividing the device timing in nanoseconds by the clock-period parameter. The SRAM and the flash therefore get their own access, pulse and recovery windows. The host data driver is enabled only while a write is in progress. A write that directly follows a read gets one extra quiet cycle before it starts. The two chip selects are never low together.

Top module: `dmem_bus_ctrl`

## Requirements
- R1: While reset is low, both chip selects, the output enable and all eight write enables are high (inactive), the data driver enable is low, the response pulse is low and the request port is ready. This holds even when reset arrives in the middle of a write pulse.
- R2: The SRAM select and the flash select are never low in the same cycle. A write enable falls only while its own device's select is low. The select of the device that was not requested stays high for the whole request.
- R3: An SRAM read (target select 0) holds the SRAM select low for one setup cycle plus ceil(25 ns / period) - 1 output-enable cycles: 1 + 2 cycles at 10 ns. The response returns the data bus value from the last output-enable cycle.
- R4: A flash read (target select 1) holds the flash select low for one setup cycle plus max(ceil(35 ns / period), ceil(90 ns / period) - 1) output-enable cycles: 1 + 8 at 10 ns. The response returns the data bus value from the last output-enable cycle.
- R5: An SRAM write keeps the output enable high. It drives SRAM write enable i low, for lane i (bits 8i+7:8i), exactly when byte enable bit i is 1. The pulse lasts max(ceil(20 ns / period), ceil(15 ns / period)) cycles, which is 2 at 10 ns.
- R6: A flash write drives flash write enable i low for each set byte enable bit for ceil(45 ns / period) cycles, which is 5 at 10 ns. It is followed by max(ceil(20 ns / period), ceil(90 ns / period) - 1 - pulse) recovery cycles, which is 3 at 10 ns.
- R7: After a read, all strobes stay high for a recovery window before the port is ready again: ceil(12 ns / period) cycles for SRAM and ceil(20 ns / period) for flash (2 and 2 at 10 ns). After an SRAM write the recovery is max(1, ceil(25 ns / period) - 1 - pulse) cycles, which is 1.
- R8: Every accepted request produces exactly one single-cycle response pulse. It comes in the first cycle after the last active-phase cycle.
- R9: The data driver enable is high only during a write request, never while the output enable is low, and always while any write enable is low. During the write pulse the driven data equals the request write data.
- R10: When a write follows a read, one cycle with all strobes high and the data driver off comes before the write's setup cycle. A read after a read, or any request after a write, starts setup directly.
- R11: The request port is ready only when no request is in progress. A request presented while the port is busy is neither accepted nor allowed to touch any strobe.
- R12: While a chip select stays low, the address and the driven write data do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle, request accepted when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_flash | input | 1 | Target: 1 = flash, 0 = SRAM |
| req_be | input | 4 | Byte enables, bit i for data bits 8i+7:8i |
| req_addr | input | 19 | Word address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Read data captured at the end of the read |
| mem_addr | output | 19 | Shared address bus |
| mem_dq_out | output | 32 | Data toward the memories |
| mem_dq_oe | output | 1 | Enable for the data driver toward the memories |
| mem_dq_in | input | 32 | Data from the memories |
| sram_cs_n | output | 1 | SRAM chip select, active low |
| flash_cs_n | output | 1 | Flash chip select, active low |
| mem_oe_n | output | 1 | Shared output enable, active low |
| sram_we_n | output | 4 | SRAM per-lane write enables, active low |
| flash_we_n | output | 4 | Flash per-lane write enables, active low |

## Verification
Most internal faults in this block show up as a wrong phase length. If the wait counter is loaded with the wrong value, or a phase is skipped, the select-low window, the output-enable window or the busy window at the ports comes out a cycle or more off. That is visible in the same request, before the response pulse. A wrong latched target or state decode shows at once as the wrong select, two selects low together, or a write enable on the wrong lane. A lost read-to-write turnaround shows as a data driver that turns on one cycle early. Read capture taken from the wrong edge shows as wrong response data, because the bench floats a marker value on the bus outside output-enable windows.

// File: rtl/dmem_pkg.sv
package dmem_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TURN,
    ST_SETUP,
    ST_ACTIVE,
    ST_RECOV
  } dmem_state_e;

  // nanoseconds to whole clock cycles, rounded up
  function automatic int unsigned cyc_of(input int unsigned ns, input int unsigned clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int unsigned at_least_one(input int unsigned c);
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned pick_max(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // cycles of a total budget left once `used` cycles are spent
  function automatic int unsigned left_after(input int unsigned total, input int unsigned used);
    return (total > used) ? total - used : 0;
  endfunction

endpackage

// File: rtl/dmem_wait_timer.sv
module dmem_wait_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] len,
  output logic             done
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= len - ONE;
    else if (cnt_q != '0)    cnt_q <= cnt_q - ONE;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/dmem_strobe_gen.sv
module dmem_strobe_gen
  import dmem_pkg::*;
#(
  parameter int unsigned LANES = 4
) (
  input  dmem_state_e      state,
  input  logic             is_flash,
  input  logic             is_write,
  input  logic [LANES-1:0] be,
  output logic             sram_cs_n,
  output logic             flash_cs_n,
  output logic             oe_n,
  output logic [LANES-1:0] sram_we_n,
  output logic [LANES-1:0] flash_we_n,
  output logic             dq_oe
);
  logic selected;
  logic pulse;

  assign selected   = (state == ST_SETUP) || (state == ST_ACTIVE);
  assign pulse      = (state == ST_ACTIVE) && is_write;
  assign sram_cs_n  = !(selected && !is_flash);
  assign flash_cs_n = !(selected && is_flash);
  assign oe_n       = !((state == ST_ACTIVE) && !is_write);
  assign dq_oe      = is_write && (selected || (state == ST_RECOV));

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign sram_we_n[g]  = !(pulse && !is_flash && be[g]);
    assign flash_we_n[g] = !(pulse && is_flash && be[g]);
  end
endmodule

// File: rtl/dmem_bus_ctrl.sv
module dmem_bus_ctrl
  import dmem_pkg::*;
#(
  parameter int unsigned CLK_NS     = 10,
  parameter int unsigned ADDR_W     = 19,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned SR_ACC_NS  = 25,
  parameter int unsigned SR_AS_NS   = 3,
  parameter int unsigned SR_WP_NS   = 20,
  parameter int unsigned SR_DW_NS   = 15,
  parameter int unsigned SR_WC_NS   = 25,
  parameter int unsigned SR_OFF_NS  = 12,
  parameter int unsigned FL_ACC_NS  = 90,
  parameter int unsigned FL_OE_NS   = 35,
  parameter int unsigned FL_AS_NS   = 0,
  parameter int unsigned FL_WP_NS   = 45,
  parameter int unsigned FL_AH_NS   = 45,
  parameter int unsigned FL_WPH_NS  = 20,
  parameter int unsigned FL_WC_NS   = 90,
  parameter int unsigned FL_OFF_NS  = 20
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_write,
  input  logic                  req_flash,
  input  logic [DATA_W/8-1:0]   req_be,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [DATA_W-1:0]     req_wdata,
  output logic                  rsp_valid,
  output logic [DATA_W-1:0]     rsp_rdata,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic [DATA_W-1:0]     mem_dq_out,
  output logic                  mem_dq_oe,
  input  logic [DATA_W-1:0]     mem_dq_in,
  output logic                  sram_cs_n,
  output logic                  flash_cs_n,
  output logic                  mem_oe_n,
  output logic [DATA_W/8-1:0]   sram_we_n,
  output logic [DATA_W/8-1:0]   flash_we_n
);
  localparam int unsigned LANES = DATA_W / 8;

  // phase lengths in cycles
  localparam int unsigned SR_SETUP  = at_least_one(cyc_of(SR_AS_NS, CLK_NS));
  localparam int unsigned SR_RD_ACT = at_least_one(left_after(cyc_of(SR_ACC_NS, CLK_NS), SR_SETUP));
  localparam int unsigned SR_RD_REC = at_least_one(cyc_of(SR_OFF_NS, CLK_NS));
  localparam int unsigned SR_WR_ACT = at_least_one(pick_max(cyc_of(SR_WP_NS, CLK_NS),
                                                            cyc_of(SR_DW_NS, CLK_NS)));
  localparam int unsigned SR_WR_REC = at_least_one(left_after(cyc_of(SR_WC_NS, CLK_NS),
                                                              SR_SETUP + SR_WR_ACT));
  localparam int unsigned FL_SETUP  = at_least_one(cyc_of(FL_AS_NS, CLK_NS));
  localparam int unsigned FL_RD_ACT = at_least_one(pick_max(cyc_of(FL_OE_NS, CLK_NS),
                                        left_after(cyc_of(FL_ACC_NS, CLK_NS), FL_SETUP)));
  localparam int unsigned FL_RD_REC = at_least_one(cyc_of(FL_OFF_NS, CLK_NS));
  localparam int unsigned FL_WR_ACT = at_least_one(pick_max(cyc_of(FL_WP_NS, CLK_NS),
                                                            cyc_of(FL_AH_NS, CLK_NS)));
  localparam int unsigned FL_WR_REC = at_least_one(pick_max(cyc_of(FL_WPH_NS, CLK_NS),
                                        left_after(cyc_of(FL_WC_NS, CLK_NS), FL_SETUP + FL_WR_ACT)));

  localparam int unsigned MAX_LEN = pick_max(pick_max(pick_max(SR_SETUP, SR_RD_ACT),
                                             pick_max(SR_RD_REC, SR_WR_ACT)),
                                    pick_max(pick_max(pick_max(SR_WR_REC, FL_SETUP),
                                             pick_max(FL_RD_ACT, FL_RD_REC)),
                                             pick_max(FL_WR_ACT, FL_WR_REC)));
  localparam int unsigned CNT_W = $clog2(MAX_LEN + 1);

  localparam logic [CNT_W-1:0] L_ONE       = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam logic [CNT_W-1:0] L_SR_SETUP  = SR_SETUP[CNT_W-1:0];
  localparam logic [CNT_W-1:0] L_SR_RD_ACT = SR_RD_ACT[CNT_W-1:0];
  localparam logic [CNT_W-1:0] L_SR_RD_REC = SR_RD_REC[CNT_W-1:0];
  localparam logic [CNT_W-1:0] L_SR_WR_ACT = SR_WR_ACT[CNT_W-1:0];
  localparam logic [CNT_W-1:0] L_SR_WR_REC = SR_WR_REC[CNT_W-1:0];
  localparam logic [CNT_W-1:0] L_FL_SETUP  = FL_SETUP[CNT_W-1:0];
  localparam logic [CNT_W-1:0] L_FL_RD_ACT = FL_RD_ACT[CNT_W-1:0];
  localparam logic [CNT_W-1:0] L_FL_RD_REC = FL_RD_REC[CNT_W-1:0];
  localparam logic [CNT_W-1:0] L_FL_WR_ACT = FL_WR_ACT[CNT_W-1:0];
  localparam logic [CNT_W-1:0] L_FL_WR_REC = FL_WR_REC[CNT_W-1:0];

  dmem_state_e          st_q, st_nx;
  logic                 cur_flash, cur_write, last_rd_q;
  logic [LANES-1:0]     cur_be;
  logic [ADDR_W-1:0]    cur_addr;
  logic [DATA_W-1:0]    cur_wdata;
  logic                 tm_load, tm_done;
  logic [CNT_W-1:0]     tm_len;
  logic [CNT_W-1:0]     setup_len, act_len, rec_len;

  // named events
  logic accept, active_end;
  assign req_ready  = (st_q == ST_IDLE);
  assign accept     = req_valid && req_ready;
  assign active_end = (st_q == ST_ACTIVE) && tm_done;

  always_comb begin
    setup_len = cur_flash ? L_FL_SETUP : L_SR_SETUP;
    unique case ({cur_flash, cur_write})
      2'b00:   begin act_len = L_SR_RD_ACT; rec_len = L_SR_RD_REC; end
      2'b01:   begin act_len = L_SR_WR_ACT; rec_len = L_SR_WR_REC; end
      2'b10:   begin act_len = L_FL_RD_ACT; rec_len = L_FL_RD_REC; end
      default: begin act_len = L_FL_WR_ACT; rec_len = L_FL_WR_REC; end
    endcase
  end

  always_comb begin
    st_nx   = st_q;
    tm_load = 1'b0;
    tm_len  = L_ONE;
    unique case (st_q)
      ST_IDLE: if (req_valid) begin
        tm_load = 1'b1;
        if (req_write && last_rd_q) begin
          st_nx  = ST_TURN;
          tm_len = L_ONE;
        end else begin
          st_nx  = ST_SETUP;
          tm_len = req_flash ? L_FL_SETUP : L_SR_SETUP;
        end
      end
      ST_TURN:   if (tm_done) begin st_nx = ST_SETUP;  tm_load = 1'b1; tm_len = setup_len; end
      ST_SETUP:  if (tm_done) begin st_nx = ST_ACTIVE; tm_load = 1'b1; tm_len = act_len;   end
      ST_ACTIVE: if (tm_done) begin st_nx = ST_RECOV;  tm_load = 1'b1; tm_len = rec_len;   end
      ST_RECOV:  if (tm_done) st_nx = ST_IDLE;
      default:   st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      cur_flash <= 1'b0;
      cur_write <= 1'b0;
      cur_be    <= '0;
      cur_addr  <= '0;
      cur_wdata <= '0;
      last_rd_q <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      st_q      <= st_nx;
      rsp_valid <= active_end;
      if (accept) begin
        cur_flash <= req_flash;
        cur_write <= req_write;
        cur_be    <= req_be;
        cur_addr  <= req_addr;
        cur_wdata <= req_wdata;
      end
      if (active_end) begin
        last_rd_q <= !cur_write;
        if (!cur_write) rsp_rdata <= mem_dq_in;
      end
    end
  end

  dmem_wait_timer #(.CNT_W(CNT_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (tm_load),
    .len   (tm_len),
    .done  (tm_done)
  );

  dmem_strobe_gen #(.LANES(LANES)) u_strobe (
    .state      (st_q),
    .is_flash   (cur_flash),
    .is_write   (cur_write),
    .be         (cur_be),
    .sram_cs_n  (sram_cs_n),
    .flash_cs_n (flash_cs_n),
    .oe_n       (mem_oe_n),
    .sram_we_n  (sram_we_n),
    .flash_we_n (flash_we_n),
    .dq_oe      (mem_dq_oe)
  );

  assign mem_addr   = cur_addr;
  assign mem_dq_out = cur_wdata;
endmodule

// File: rtl/dmem_bus_chk.sv
module dmem_bus_chk #(
  parameter int unsigned LANES  = 4,
  parameter int unsigned ADDR_W = 19,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              sram_cs_n,
  input logic              flash_cs_n,
  input logic              mem_oe_n,
  input logic [LANES-1:0]  sram_we_n,
  input logic [LANES-1:0]  flash_we_n,
  input logic              mem_dq_oe,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_dq_out
);
  logic any_cs, any_we;
  assign any_cs = !sram_cs_n || !flash_cs_n;
  assign any_we = !(&sram_we_n) || !(&flash_we_n);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_quiet_R1: assert (sram_cs_n && flash_cs_n && mem_oe_n && (&sram_we_n)
                                     && (&flash_we_n) && !mem_dq_oe && !rsp_valid && req_ready);
    end
  end

  assert_cs_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_cs_n |-> flash_cs_n);
  assert_sram_we_cs_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(&sram_we_n) |-> !sram_cs_n);
  assert_flash_we_cs_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(&flash_we_n) |-> !flash_cs_n);
  assert_oe_no_we_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (&sram_we_n) && (&flash_we_n));
  assert_drive_no_oe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);
  assert_we_driven_R9: assert property (@(posedge clk) disable iff (!rst_n)
    any_we |-> mem_dq_oe);
  assert_rsp_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  assert_rsp_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);
  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !any_cs && mem_oe_n && !mem_dq_oe);
  assert_bus_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (any_cs && $past(any_cs)) |-> $stable(mem_addr) && $stable(mem_dq_out));
endmodule

bind dmem_bus_ctrl dmem_bus_chk #(.LANES(LANES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .sram_cs_n  (sram_cs_n),
  .flash_cs_n (flash_cs_n),
  .mem_oe_n   (mem_oe_n),
  .sram_we_n  (sram_we_n),
  .flash_we_n (flash_we_n),
  .mem_dq_oe  (mem_dq_oe),
  .mem_addr   (mem_addr),
  .mem_dq_out (mem_dq_out)
);

// File: tb/dmem_bus_ctrl_bench.sv
module dmem_bus_ctrl_bench;
  localparam int T = 10;

  // expected windows, from the requirement formulas
  function automatic int up(input int ns); return (ns + T - 1) / T; endfunction
  function automatic int mx(input int a, input int b); return (a > b) ? a : b; endfunction
  function automatic int act_cycles(input bit fl, input bit wr);
    if (!fl && !wr) return up(25) - 1;
    if ( fl && !wr) return mx(up(35), up(90) - 1);
    if (!fl &&  wr) return mx(up(20), up(15));
    return up(45);
  endfunction
  function automatic int rec_cycles(input bit fl, input bit wr);
    if (!fl && !wr) return up(12);
    if ( fl && !wr) return up(20);
    if (!fl &&  wr) return mx(1, up(25) - 1 - act_cycles(1'b0, 1'b1));
    return mx(up(20), up(90) - 1 - act_cycles(1'b1, 1'b1));
  endfunction
  function automatic logic [31:0] sram_pat(input logic [18:0] a);
    return 32'h5A5A_0000 ^ {13'd0, a};
  endfunction
  function automatic logic [31:0] flash_pat(input logic [18:0] a);
    return 32'hC3C3_FFFF ^ {13'd0, a};
  endfunction

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_flash = 1'b0;
  logic [3:0] req_be = 4'h0;
  logic [18:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready, rsp_valid, mem_dq_oe, sram_cs_n, flash_cs_n, mem_oe_n;
  logic [31:0] rsp_rdata, mem_dq_out, mem_dq_in;
  logic [18:0] mem_addr;
  logic [3:0] sram_we_n, flash_we_n;

  always #(T/2) clk = ~clk;

  assign mem_dq_in = (!mem_oe_n && !sram_cs_n)  ? sram_pat(mem_addr)  :
                     (!mem_oe_n && !flash_cs_n) ? flash_pat(mem_addr) : 32'hDEAD_0BAD;

  dmem_bus_ctrl u_dmem_bus_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_flash(req_flash), .req_be(req_be), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in), .sram_cs_n(sram_cs_n), .flash_cs_n(flash_cs_n),
    .mem_oe_n(mem_oe_n), .sram_we_n(sram_we_n), .flash_we_n(flash_we_n)
  );

  int total = 0, bad = 0;
  bit prev_read = 1'b0;

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // {flash, write, be, addr, wdata}
  localparam logic [56:0] VECS [8] = '{
    {1'b0, 1'b0, 4'hF, 19'h00123, 32'h0000_0000},
    {1'b0, 1'b1, 4'hF, 19'h00124, 32'hA5A5_1234},
    {1'b1, 1'b0, 4'hF, 19'h7FFFF, 32'h0000_0000},
    {1'b1, 1'b0, 4'h3, 19'h00000, 32'h0000_0000},
    {1'b1, 1'b1, 4'h5, 19'h2AAAA, 32'h1122_3344},
    {1'b0, 1'b1, 4'h8, 19'h15555, 32'hCAFE_F00D},
    {1'b0, 1'b0, 4'hF, 19'h40000, 32'h0000_0000},
    {1'b1, 1'b1, 4'hF, 19'h01000, 32'h8765_4321}
  };

  task automatic run_txn(input bit fl, input bit wr, input logic [3:0] be,
                         input logic [18:0] a, input logic [31:0] d, input bit hold_other);
    string tg = fl ? (wr ? "R6" : "R4") : (wr ? "R5" : "R3");
    int act = act_cycles(fl, wr);
    int rec = rec_cycles(fl, wr);
    int turn = (wr && prev_read) ? 1 : 0;
    int busy = 0, own_cs = 0, other_cs = 0, both = 0, oe_cnt = 0, we_cnt = 0;
    int rsp_cnt = 0, rsp_at = 0, lane_bad = 0, drv_bad = 0, addr_bad = 0, turn_bad = 0;
    logic [31:0] rd_got = '0;
    @(negedge clk);
    check("R11", "ready before request", {31'd0, req_ready}, 32'd1);
    req_valid = 1'b1; req_flash = fl; req_write = wr; req_be = be; req_addr = a; req_wdata = d;
    @(negedge clk);
    if (hold_other) begin
      req_flash = !fl; req_write = 1'b1; req_be = 4'hF; req_addr = 19'h3FFFF; req_wdata = 32'hFFFF_0000;
    end else req_valid = 1'b0;
    while (!req_ready && busy < 64) begin
      busy++;
      if (!sram_cs_n && !flash_cs_n) both++;
      if (fl ? !flash_cs_n : !sram_cs_n) own_cs++;
      if (fl ? !sram_cs_n : !flash_cs_n) other_cs++;
      if (!mem_oe_n) oe_cnt++;
      if (!(&sram_we_n) || !(&flash_we_n)) begin
        we_cnt++;
        if ((fl ? flash_we_n : sram_we_n) !== ~be || (fl ? sram_we_n : flash_we_n) !== 4'hF) lane_bad++;
        if (!mem_dq_oe || mem_dq_out !== d) drv_bad++;
      end
      if (mem_dq_oe && !wr) drv_bad++;
      if ((!sram_cs_n || !flash_cs_n) && mem_addr !== a) addr_bad++;
      if (turn == 1 && busy == 1 &&
          (!sram_cs_n || !flash_cs_n || !mem_oe_n || mem_dq_oe || !(&sram_we_n) || !(&flash_we_n)))
        turn_bad++;
      if (rsp_valid) begin rsp_cnt++; rsp_at = busy; rd_got = rsp_rdata; end
      @(negedge clk);
    end
    req_valid = 1'b0;
    check(turn ? "R10" : (wr ? "R6" : "R7"), "busy cycles", busy, turn + 1 + act + rec);
    check(tg, "select low cycles", own_cs, 1 + act);
    check("R2", "other select low", other_cs, 0);
    check("R2", "both selects low", both, 0);
    check(tg, "output enable cycles", oe_cnt, wr ? 0 : act);
    check(tg, "write pulse cycles", we_cnt, wr ? act : 0);
    check("R8", "response count", rsp_cnt, 1);
    check("R8", "response position", rsp_at, turn + 1 + act + 1);
    if (!wr) check(tg, "read data", rd_got, fl ? flash_pat(a) : sram_pat(a));
    check("R5", "lane pattern errors", lane_bad, 0);
    check("R9", "driver errors", drv_bad, 0);
    check("R12", "address errors", addr_bad, 0);
    if (turn == 1) check("R10", "turnaround quiet", turn_bad, 0);
    if (hold_other) check("R11", "held request touched strobes", other_cs, 0);
    prev_read = !wr;
  endtask

  initial begin
    #(T * 200000);
    bad++; total++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1: reset state, with a request pending during reset
    req_valid = 1'b1; req_flash = 1'b1; req_write = 1'b1; req_be = 4'hF;
    repeat (3) @(negedge clk);
    check("R1", "reset strobes", {26'd0, sram_cs_n, flash_cs_n, mem_oe_n, mem_dq_oe, req_ready, rsp_valid},
          32'b111_0_1_0);
    check("R1", "reset write enables", {24'd0, sram_we_n, flash_we_n}, 32'hFF);
    req_valid = 1'b0;
    rst_n = 1'b1;

    for (int i = 0; i < 8; i++) begin
      run_txn(VECS[i][56], VECS[i][55], VECS[i][54:51], VECS[i][50:32], VECS[i][31:0], 1'b0);
    end

    // R11: request of the other target held valid through a busy SRAM read
    run_txn(1'b0, 1'b0, 4'hF, 19'h00777, 32'h0, 1'b1);
    // R10: read to read starts directly, write after write starts directly
    run_txn(1'b1, 1'b0, 4'hF, 19'h00778, 32'h0, 1'b0);
    run_txn(1'b0, 1'b1, 4'h2, 19'h00779, 32'h0BAD_CAFE, 1'b0);
    run_txn(1'b1, 1'b1, 4'h1, 19'h0077A, 32'h0000_00EE, 1'b0);

    // R1: reset during a flash write pulse
    @(negedge clk);
    req_valid = 1'b1; req_flash = 1'b1; req_write = 1'b1; req_be = 4'hF;
    req_addr = 19'h00042; req_wdata = 32'h600D_600D;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    check("R6", "pulse active before reset", {28'd0, flash_we_n}, 32'h0);
    rst_n = 1'b0;
    #1;
    check("R1", "strobes after mid-write reset",
          {24'd0, sram_we_n, flash_we_n}, 32'hFF);
    check("R1", "selects and driver after mid-write reset",
          {28'd0, sram_cs_n, flash_cs_n, mem_oe_n, mem_dq_oe}, 32'b1110);
    @(negedge clk);
    rst_n = 1'b1;
    prev_read = 1'b0;
    run_txn(1'b1, 1'b0, 4'hF, 19'h00042, 32'h0, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule